// File: doc/BRIEF.md
# Reference-Compare Timer with Input Capture

This block is a 16-bit up-counter for timing and event measurement. A programmable 8-bit prescaler divides one of several tick sources. On every counted tick the counter is compared with a reference value. A match sets a sticky event flag and can raise an interrupt. Depending on a mode bit, the count then either restarts from zero or runs on past the reference. On each match a dedicated output pin gives either a one-cycle low pulse or a change of level.

A second input pin is synchronised and watched for edges. On the chosen edge the running count is copied into a capture register and a second event flag is set. Software controls everything through a small synchronous register port and may rewrite any register while the counter runs. Reads are combinational on the address. Writes take effect at the next clock edge.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `tmr_out` is high.
- R2: While mode bit 0 (enable) is 0, the counter and the prescaler are held at zero and no match can occur.
- R3: The prescaler passes one counted tick for every (mode[15:8] + 1) source ticks.
- R4: A counted tick that finds the counter equal to the reference sets the reference flag, bit 1 of the event register, on the following edge.
- R5: With mode bit 3 set, a match loads zero into the counter. With it clear, the counter increments past the reference and wraps at 16 bits.
- R6: `irq` is high exactly while the reference flag is set and mode bit 4 is 1.
- R7: With mode bit 5 at 0, `tmr_out` idles high and is low for one cycle after each match.
- R8: With mode bit 5 at 1, `tmr_out` inverts its level after each match and otherwise holds it.
- R9: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: mode[7:6] selects the capture edge of `cap_in` after a two-flop synchroniser: 00 none, 01 rising, 10 falling, 11 either. On that edge the current count is copied to the capture register and bit 0 of the event register is set.
- R11: Register addresses are 0 mode, 1 reference, 2 capture (read-only; writes are ignored), 3 counter (a write loads the value unless the timer is disabled), and 4 event. Other addresses read 0. Writes are accepted at any time.
- R12: mode[2:1] selects the tick source: 00 none, 01 every system clock, 10 one clock in 16, 11 rising edges of `ext_clk_in` after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ext_clk_in | input | 1 | External tick input, asynchronous |
| cap_in | input | 1 | Capture trigger input, asynchronous |
| irq | output | 1 | Reference-match interrupt |
| tmr_out | output | 1 | Match output, pulse or toggle |

## Verification
The hardest case to reach is a write that clears a flag landing in the same cycle as a new event for that flag, because matches normally come many cycles apart. The stimulus sets the reference to zero with restart and no prescaling, so a match occurs on every counted tick. It then writes clear masks to the event register on alternating cycles while a cycle-accurate model follows the flags. Capture edges are driven against all three edge selections, including pulses that are only a few cycles wide, so the two-flop delay is checked for both edge directions.

// File: rtl/refcmp_timer_pkg.sv
`timescale 1ns/1ps
package refcmp_timer_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_ANY  = 2'b11
    } cedge_e;

    // Packed MSB first: the field positions are the software-visible layout.
    typedef struct packed {
        logic [7:0] ps;
        cedge_e     cedge;
        logic       toggle;
        logic       irq_en;
        logic       restart;
        src_e       src;
        logic       en;
    } mode_t;

    localparam int ADR_MODE = 0;
    localparam int ADR_REF  = 1;
    localparam int ADR_CAP  = 2;
    localparam int ADR_CNT  = 3;
    localparam int ADR_EVT  = 4;

    localparam int EVT_CAP_BIT = 0;
    localparam int EVT_REF_BIT = 1;

endpackage

// File: rtl/rct_sync.sv
`timescale 1ns/1ps
module rct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_now,
    output logic sync_prev
);
    // chain_q[0] is the first stage and chain_q[STAGES] keeps the previous synchronised value.
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_now  = chain_q[STAGES-1];
    assign sync_prev = chain_q[STAGES];

endmodule

// File: rtl/rct_tick_gen.sv
`timescale 1ns/1ps
module rct_tick_gen
    import refcmp_timer_pkg::*;
#(
    parameter int PS_W     = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  src_e            src,
    input  logic [PS_W-1:0] ps,
    input  logic            ext_rise,
    output logic            cnt_tick
);
    localparam int DIV_W = $clog2(SLOW_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PS_W-1:0]  pre;
    } tick_st_t;

    tick_st_t cur_q, nxt_d;
    logic     src_tick;

    always_comb begin
        nxt_d    = cur_q;
        src_tick = 1'b0;
        unique case (src)
            SRC_SYS:  src_tick = 1'b1;
            SRC_SLOW: src_tick = (cur_q.div == DIV_LAST);
            SRC_EXT:  src_tick = ext_rise;
            default:  src_tick = 1'b0;
        endcase
        // A limit at or below the current phase ends the period at once.
        cnt_tick = en && src_tick && (cur_q.pre >= ps);
        if (!en) begin
            nxt_d = '0;
        end else begin
            nxt_d.div = (cur_q.div == DIV_LAST) ? '0 : DIV_W'(cur_q.div + 1'b1);
            if (src_tick) begin
                nxt_d.pre = cnt_tick ? '0 : PS_W'(cur_q.pre + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R3: a counted tick starts a new prescaler period
    a_r3_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && en) |=> (cur_q.pre == '0));

    // R2: disabled timer parks the prescaler
    a_r2_pre_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cur_q.pre == '0) && (cur_q.div == '0));

endmodule

// File: rtl/rct_count_core.sv
`timescale 1ns/1ps
module rct_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic             toggle,
    input  logic [CNT_W-1:0] refv,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             out_pin
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } core_st_t;

    core_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        match = en && tick && (cur_q.cnt == refv);

        if (!en)                 nxt_d.cnt = '0;
        else if (load)           nxt_d.cnt = load_val;
        else if (match && restart) nxt_d.cnt = '0;
        else if (tick)           nxt_d.cnt = CNT_W'(cur_q.cnt + 1'b1);

        if (toggle) nxt_d.out = cur_q.out ^ match;
        else        nxt_d.out = ~match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{cnt: '0, out: 1'b1};
        else        cur_q <= nxt_d;
    end

    assign cnt     = cur_q.cnt;
    assign out_pin = cur_q.out;

    // R5: restart mode returns to zero after a match
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (match && restart && !load) |=> (cur_q.cnt == '0));

    // R2: disabled counter reads zero
    a_r2_cnt_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cur_q.cnt == '0));

    // R7: pulse mode is high whenever no match occurred
    a_r7_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle && !match) |=> out_pin);

    // R8: toggle mode flips on a match
    a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && match) |=> (out_pin != $past(out_pin)));

endmodule

// File: rtl/refcmp_timer.sv
`timescale 1ns/1ps
module refcmp_timer
    import refcmp_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_DIV    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic              irq,
    output logic              tmr_out
);
    localparam int PS_W = 8;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] refv;
        logic [CNT_W-1:0] cap;
        logic             cap_flag;
        logic             ref_flag;
    } regs_t;

    regs_t            cur_q, nxt_d;
    logic             ext_now, ext_prev, cap_now, cap_prev;
    logic             ext_rise, cnt_tick, match, cap_hit;
    logic             wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt;
    logic [CNT_W-1:0] cnt;

    rct_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in),
        .sync_now(ext_now), .sync_prev(ext_prev)
    );

    rct_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cap_in),
        .sync_now(cap_now), .sync_prev(cap_prev)
    );

    assign ext_rise = ext_now && !ext_prev;

    rct_tick_gen #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(cur_q.mode.en), .src(cur_q.mode.src),
        .ps(cur_q.mode.ps), .ext_rise(ext_rise), .cnt_tick(cnt_tick)
    );

    rct_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(cur_q.mode.en), .tick(cnt_tick),
        .restart(cur_q.mode.restart), .toggle(cur_q.mode.toggle),
        .refv(cur_q.refv), .load(wr_cnt), .load_val(reg_wdata[CNT_W-1:0]),
        .cnt(cnt), .match(match), .out_pin(tmr_out)
    );

    always_comb begin
        nxt_d   = cur_q;
        wr_mode = reg_wr && (reg_addr == ADDR_W'(ADR_MODE));
        wr_ref  = reg_wr && (reg_addr == ADDR_W'(ADR_REF));
        wr_cap  = reg_wr && (reg_addr == ADDR_W'(ADR_CAP));
        wr_cnt  = reg_wr && (reg_addr == ADDR_W'(ADR_CNT));
        wr_evt  = reg_wr && (reg_addr == ADDR_W'(ADR_EVT));

        unique case (cur_q.mode.cedge)
            CAP_RISE: cap_hit = cap_now && !cap_prev;
            CAP_FALL: cap_hit = !cap_now && cap_prev;
            CAP_ANY:  cap_hit = cap_now != cap_prev;
            default:  cap_hit = 1'b0;
        endcase

        if (wr_mode) nxt_d.mode = mode_t'(reg_wdata);
        if (wr_ref)  nxt_d.refv = reg_wdata[CNT_W-1:0];
        if (cap_hit) nxt_d.cap  = cnt;

        nxt_d.cap_flag = cap_hit | (cur_q.cap_flag & ~(wr_evt & reg_wdata[EVT_CAP_BIT]));
        nxt_d.ref_flag = match   | (cur_q.ref_flag & ~(wr_evt & reg_wdata[EVT_REF_BIT]));

        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(ADR_MODE): reg_rdata = cur_q.mode;
            ADDR_W'(ADR_REF):  reg_rdata = REG_W'(cur_q.refv);
            ADDR_W'(ADR_CAP):  reg_rdata = REG_W'(cur_q.cap);
            ADDR_W'(ADR_CNT):  reg_rdata = REG_W'(cnt);
            ADDR_W'(ADR_EVT):  begin
                reg_rdata[EVT_CAP_BIT] = cur_q.cap_flag;
                reg_rdata[EVT_REF_BIT] = cur_q.ref_flag;
            end
            default:           reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign irq = cur_q.ref_flag && cur_q.mode.irq_en;

    // R4: a match raises the reference flag
    a_r4_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cur_q.ref_flag);

    // R10: a capture edge raises the capture flag
    a_r10_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> cur_q.cap_flag);

    // R9: clear without a competing event empties the flag
    a_r9_clear_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && reg_wdata[EVT_REF_BIT] && !match) |=> !cur_q.ref_flag);

    // R11: capture register ignores software writes
    a_r11_capture_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cap && !cap_hit) |=> $stable(cur_q.cap));

endmodule

// File: tb/refcmp_timer_tb.sv
`timescale 1ns/1ps
module refcmp_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        ext_clk_in, cap_in;
    logic        irq, tmr_out;

    always #10 clk = ~clk;

    refcmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk_in(ext_clk_in),
        .cap_in(cap_in), .irq(irq), .tmr_out(tmr_out)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";
    bit    ext_v = 0, cap_v = 0;

    // behavioural model state
    int m_mode, m_ref, m_cap, m_cnt, m_pre, m_div, m_cf, m_rf, m_out;
    int se[3], sc[3];

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_mode;
            1: return m_ref;
            2: return m_cap;
            3: return m_cnt;
            4: return (m_rf << 1) | m_cf;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input int a, input bit w, input int d);
        int en, src, ps, rs, tg, ce, srct, tick, match, capev;
        int n_cnt, n_pre, n_div, n_out;
        bit er, cr, cf;
        en = m_mode & 1; src = (m_mode >> 1) & 3; rs = (m_mode >> 3) & 1;
        tg = (m_mode >> 5) & 1; ce = (m_mode >> 6) & 3; ps = (m_mode >> 8) & 255;
        er = se[1] && !se[2];
        cr = sc[1] && !sc[2];
        cf = !sc[1] && sc[2];
        srct  = (src == 1) || (src == 2 && m_div == 15) || (src == 3 && er);
        tick  = en && srct && (m_pre >= ps);
        match = tick && (m_cnt == m_ref);
        capev = (ce == 1 && cr) || (ce == 2 && cf) || (ce == 3 && (cr || cf));

        if (!en)                 n_cnt = 0;
        else if (w && a == 3)    n_cnt = d & 16'hFFFF;
        else if (match && rs)    n_cnt = 0;
        else if (tick)           n_cnt = (m_cnt + 1) & 16'hFFFF;
        else                     n_cnt = m_cnt;
        n_pre = !en ? 0 : (srct ? (tick ? 0 : m_pre + 1) : m_pre);
        n_div = !en ? 0 : (m_div + 1) % 16;
        n_out = tg ? (m_out ^ match) : (match ? 0 : 1);

        if (capev) m_cap = m_cnt;
        m_cf = capev | (m_cf & ~((w && a == 4) ? (d & 1) : 0));
        m_rf = match | (m_rf & ~((w && a == 4) ? ((d >> 1) & 1) : 0));
        if (w && a == 0) m_mode = d & 16'hFFFF;
        if (w && a == 1) m_ref  = d & 16'hFFFF;
        m_cnt = n_cnt; m_pre = n_pre; m_div = n_div; m_out = n_out;
        se[2] = se[1]; se[1] = se[0]; se[0] = ext_v;
        sc[2] = sc[1]; sc[1] = sc[0]; sc[0] = cap_v;
    endtask

    task automatic cycle(input int a, input bit w, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wr = w; reg_wdata = 16'(d);
        ext_clk_in = ext_v; cap_in = cap_v;
        #1;
        chk("rdata", int'(reg_rdata), exp_rdata(a));
        chk("irq", int'(irq), m_rf & ((m_mode >> 4) & 1));
        chk("tmr_out", int'(tmr_out), m_out);
        model_step(a, w, d);
    endtask

    task automatic run(input int n, input int a);
        for (int i = 0; i < n; i++) cycle(a, 0, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
        summary();
    end

    initial begin
        rst_n = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        ext_clk_in = 0; cap_in = 0;
        m_mode = 0; m_ref = 0; m_cap = 0; m_cnt = 0; m_pre = 0; m_div = 0;
        m_cf = 0; m_rf = 0; m_out = 1;
        for (int i = 0; i < 3; i++) begin se[i] = 0; sc[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        cur_req = "R1";
        for (int a = 0; a < 8; a++) cycle(a, 0, 0);

        // restart, pulse, interrupt
        cur_req = "R4/R5/R6/R7";
        cycle(1, 1, 5);
        cycle(0, 1, 16'h001B);
        run(40, 3);
        run(10, 4);

        cur_req = "R9";
        cycle(4, 1, 2);
        run(3, 4);

        cur_req = "R3";
        cycle(0, 1, 16'h031B);
        run(60, 3);
        cycle(0, 1, 16'h011B);
        run(30, 3);

        // free-run, toggle, wrap, counter load
        cur_req = "R5/R8/R11";
        cycle(1, 1, 2);
        cycle(0, 1, 16'h0033);
        cycle(3, 1, 16'hFFF8);
        run(40, 3);
        cycle(4, 1, 3);
        run(5, 4);

        cur_req = "R12";
        cycle(1, 1, 3);
        cycle(0, 1, 16'h001D);
        run(200, 3);
        cycle(0, 1, 16'h011F);
        cycle(1, 1, 4);
        for (int i = 0; i < 150; i++) begin
            ext_v = ((i / 3) % 2) != 0;
            cycle(3, 0, 0);
        end
        ext_v = 0;
        cycle(0, 1, 16'h0019);
        run(20, 3);

        cur_req = "R10";
        for (int m = 1; m < 4; m++) begin
            cycle(0, 1, (m << 6) | 16'h0003);
            for (int i = 0; i < 80; i++) begin
                cap_v = (i % 11) < ((i < 40) ? 7 : 2);
                cycle((i % 2) ? 2 : 4, (i % 13) == 12, 1);
            end
        end
        cap_v = 0;
        run(5, 2);

        cur_req = "R11";
        cycle(2, 1, 16'hABCD);
        cycle(2, 0, 0);
        cycle(6, 1, 16'h1234);
        for (int a = 5; a < 8; a++) cycle(a, 0, 0);
        cycle(3, 1, 16'h0100);
        run(4, 3);

        cur_req = "R2";
        cycle(0, 1, 16'h001A);
        cycle(3, 1, 16'h0055);
        run(20, 3);
        cycle(0, 1, 16'h001B);
        run(10, 3);

        // match on every tick against clears
        cur_req = "R9/R4/R6";
        cycle(1, 1, 0);
        cycle(0, 1, 16'h001B);
        for (int i = 0; i < 40; i++) cycle(4, (i % 2) == 0, (i % 3 == 0) ? 3 : 2);
        cycle(0, 1, 16'h0010);
        cycle(4, 1, 3);
        run(3, 4);

        cur_req = "R3/R12/R10/R9";
        for (int i = 0; i < 1500; i++) begin
            int a;
            bit w;
            int d;
            a = $urandom_range(0, 7);
            w = ($urandom_range(0, 15) == 0);
            d = $urandom_range(0, 16'hFFFF);
            if (w && a == 0) d = d & 16'h03FF;
            ext_v = $urandom_range(0, 1);
            cap_v = ($urandom_range(0, 3) == 0) ? ~cap_v : cap_v;
            cycle(a, w, d);
        end

        summary();
    end

endmodule